// File: doc/BRIEF.md
# Pulse Wave Timer

An 8-bit timer that produces a programmable rectangular wave. An up counter steps once per tick from a selectable count source. The count is compared against two values: a duty compare value and a period compare value. The counter returns to zero after the period match, so one wave cycle lasts the period value plus one ticks. The output flip-flop inverts on each of the two matches, which gives one pulse per cycle. The pulse width is set by the duty value.

Software programs the block through a single write port that selects one of four targets. The duty value can be double-buffered. In that case a new duty value waits in a holding register and only takes effect at the next period match, so a changing duty never produces a broken cycle. The two matches also drive two separate one-cycle interrupt pulses. The output level can be preset by a write, which sets the starting polarity. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `pulse_wave_timer`

## Requirements
- R1: During reset and after it: `wave_out`, `irq_duty` and `irq_period` are 0. The duty value is 0, the period value is all ones and every control bit is 0, so the counter is stopped. With only the run bit written after reset, period matches come every 256 ticks.
- R2: A write is a one-cycle `wr_en` with `wr_sel` choosing the target: 0 = duty value, 1 = period value, 2 = control, 3 = output preset. The control byte holds run in bit 0, double-buffer enable in bit 1, count source in bits 3:2 and invert enable in bit 4.
- R3: While running, the counter steps by one on each selected tick. On a tick where it equals the period value it returns to 0 instead. `irq_period` pulses for one cycle after that tick, so period pulses are period+1 ticks apart.
- R4: On a tick where the counter equals the active duty value, `irq_duty` pulses for one cycle after that tick. This comes duty+1 ticks after the preceding period pulse.
- R5: With invert enable set, `wave_out` inverts on each duty match and on each period match, in the same cycle as the interrupt pulse.
- R6: With invert enable clear, `wave_out` holds its level while both interrupt pulses keep occurring.
- R7: The count source is selected as follows: 0 = `tick_div1`, 1 = `tick_div4`, 2 = `tick_div16`, 3 = `ext_count`. Each is a one-cycle clock-enable strobe, and match spacing scales with the strobe spacing.
- R8: Clearing the run bit forces the counter to 0 and holds it there. No matches occur and `wave_out` keeps its level. After run is set again, the first duty match comes duty+1 ticks after the write.
- R9: With double buffering off, a duty write changes the active duty value at once and also loads the holding register.
- R10: With double buffering on, a duty write only loads the holding register. The holding register is copied into the active duty value on each period match.
- R11: A preset write sets `wave_out` to `wr_data[0]` in the next cycle. It overrides a match inversion in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target select |
| wr_data | input | 8 | Write data |
| tick_div1 | input | 1 | Count strobe, full rate |
| tick_div4 | input | 1 | Count strobe, quarter rate |
| tick_div16 | input | 1 | Count strobe, one-sixteenth rate |
| ext_count | input | 1 | External count strobe |
| wave_out | output | 1 | Rectangular wave output |
| irq_duty | output | 1 | Duty match interrupt pulse |
| irq_period | output | 1 | Period match interrupt pulse |

## Verification
The assertions check the following on every cycle:
- a stopped counter sits at zero;
- the counter only ever steps by one or returns to zero;
- a period pulse always leaves the counter at zero;
- the output only changes with a match pulse or a preset write, and never while inversion is disabled;
- the active duty value only changes on a direct write or at a period match.

The actual tick spacings need the bench's scenarios:
- duty+1 and period+1 spacing across a sweep of duty and period values;
- the scaling for each count source;
- the deferred effect of a buffered duty write;
- the restart timing after the run bit is cleared and set again;
- preset priority over a coincident match.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

  typedef enum logic [1:0] {
    SEL_DUTY   = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_PRESET = 2'd3
  } wr_sel_e;

  typedef enum logic [1:0] {
    SRC_DIV1  = 2'd0,
    SRC_DIV4  = 2'd1,
    SRC_DIV16 = 2'd2,
    SRC_EXT   = 2'd3
  } cnt_src_e;

  // packed MSB first: [4] invert enable, [3:2] source, [1] double buffer, [0] run
  typedef struct packed {
    logic     inv_en;
    cnt_src_e src;
    logic     dbuf_en;
    logic     run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int N_SRC  = 4;

endpackage

// File: rtl/pwt_rst_sync.sv
module pwt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shift_q[STAGES-1];

endmodule

// File: rtl/pwt_tick_mux.sv
module pwt_tick_mux
  import pwt_pkg::*;
#(
  parameter int NSRC = N_SRC
) (
  input  logic [NSRC-1:0] tick_vec,
  input  cnt_src_e        src,
  output logic            tick
);

  localparam int SEL_W = $clog2(NSRC);

  logic [NSRC-1:0] hit;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i] = tick_vec[i] && (src == SEL_W'(i));
  end

  assign tick = |hit;

endmodule

// File: rtl/pwt_regs.sv
module pwt_regs
  import pwt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             period_hit,
  output logic [CNT_W-1:0] duty_act,
  output logic [CNT_W-1:0] period_val,
  output ctrl_t            ctrl,
  output logic             preset_wr,
  output logic             preset_val
);

  logic [CNT_W-1:0] duty_act_q, duty_act_d;
  logic [CNT_W-1:0] duty_buf_q, duty_buf_d;
  logic [CNT_W-1:0] period_q, period_d;
  ctrl_t            ctrl_q, ctrl_d;
  logic             duty_wr, period_wr, ctrl_wr;

  always_comb begin
    duty_wr    = wr_en && (wr_sel == SEL_DUTY);
    period_wr  = wr_en && (wr_sel == SEL_PERIOD);
    ctrl_wr    = wr_en && (wr_sel == SEL_CTRL);
    preset_wr  = wr_en && (wr_sel == SEL_PRESET);
    preset_val = wr_data[0];

    duty_act_d = duty_act_q;
    duty_buf_d = duty_buf_q;
    period_d   = period_q;
    ctrl_d     = ctrl_q;

    // buffered value moves into the compare path at the period match
    if (ctrl_q.dbuf_en && period_hit) duty_act_d = duty_buf_q;

    if (duty_wr) begin
      duty_buf_d = wr_data;
      if (!ctrl_q.dbuf_en) duty_act_d = wr_data;
    end

    if (period_wr) period_d = wr_data;
    if (ctrl_wr)   ctrl_d   = ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_act_q <= '0;
      duty_buf_q <= '0;
      period_q   <= '1;
      ctrl_q     <= '0;
    end else begin
      duty_act_q <= duty_act_d;
      duty_buf_q <= duty_buf_d;
      period_q   <= period_d;
      ctrl_q     <= ctrl_d;
    end
  end

  assign duty_act   = duty_act_q;
  assign period_val = period_q;
  assign ctrl       = ctrl_q;

endmodule

// File: rtl/pwt_count_cmp.sv
module pwt_count_cmp #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] duty_cmp,
  input  logic [CNT_W-1:0] period_cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             duty_hit,
  output logic             period_hit
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;

  always_comb begin
    step       = run && tick;
    duty_hit   = step && (cnt_q == duty_cmp);
    period_hit = step && (cnt_q == period_cmp);

    cnt_d = cnt_q;
    if (!run)            cnt_d = '0;
    else if (period_hit) cnt_d = '0;
    else if (step)       cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/pwt_wave_out.sv
module pwt_wave_out (
  input  logic clk,
  input  logic rst_n,
  input  logic duty_hit,
  input  logic period_hit,
  input  logic inv_en,
  input  logic preset_wr,
  input  logic preset_val,
  output logic wave,
  output logic irq_duty,
  output logic irq_period
);

  logic wave_q, wave_d, toggle;
  logic irq_duty_q, irq_period_q;

  always_comb begin
    toggle = inv_en && (duty_hit ^ period_hit);
    if (preset_wr) wave_d = preset_val;
    else           wave_d = wave_q ^ toggle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_q       <= 1'b0;
      irq_duty_q   <= 1'b0;
      irq_period_q <= 1'b0;
    end else begin
      wave_q       <= wave_d;
      irq_duty_q   <= duty_hit;
      irq_period_q <= period_hit;
    end
  end

  assign wave       = wave_q;
  assign irq_duty   = irq_duty_q;
  assign irq_period = irq_period_q;

endmodule

// File: rtl/pulse_wave_timer.sv
module pulse_wave_timer
  import pwt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             tick_div1,
  input  logic             tick_div4,
  input  logic             tick_div16,
  input  logic             ext_count,
  output logic             wave_out,
  output logic             irq_duty,
  output logic             irq_period
);

  logic             rst_core_n;
  logic             tick;
  logic [CNT_W-1:0] duty_act, period_val, cnt_q;
  ctrl_t            ctrl_q;
  logic             preset_wr, preset_val;
  logic             duty_hit, period_hit;
  logic [N_SRC-1:0] tick_vec;

  assign tick_vec = {ext_count, tick_div16, tick_div4, tick_div1};

  pwt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  pwt_tick_mux #(.NSRC(N_SRC)) u_mux (
    .tick_vec (tick_vec),
    .src      (ctrl_q.src),
    .tick     (tick)
  );

  pwt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .period_hit (period_hit),
    .duty_act   (duty_act),
    .period_val (period_val),
    .ctrl       (ctrl_q),
    .preset_wr  (preset_wr),
    .preset_val (preset_val)
  );

  pwt_count_cmp #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .run        (ctrl_q.run),
    .tick       (tick),
    .duty_cmp   (duty_act),
    .period_cmp (period_val),
    .cnt        (cnt_q),
    .duty_hit   (duty_hit),
    .period_hit (period_hit)
  );

  pwt_wave_out u_wave (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .duty_hit   (duty_hit),
    .period_hit (period_hit),
    .inv_en     (ctrl_q.inv_en),
    .preset_wr  (preset_wr),
    .preset_val (preset_val),
    .wave       (wave_out),
    .irq_duty   (irq_duty),
    .irq_period (irq_period)
  );

endmodule

// File: rtl/pwt_checker.sv
module pwt_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic             wave_out,
  input logic             irq_duty,
  input logic             irq_period,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] duty_act,
  input logic             run,
  input logic             inv_en,
  input logic             dbuf_en
);

  logic preset_w, duty_w;
  assign preset_w = wr_en && (wr_sel == 2'd3);
  assign duty_w   = wr_en && (wr_sel == 2'd0);

  // R8
  stopped_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> ((cnt == $past(cnt) + CNT_W'(1)) || (cnt == '0)));

  // R3
  period_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_period |-> (cnt == '0));

  // R5
  wave_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_out != $past(wave_out)) |-> ($past(preset_w) || irq_duty || irq_period));

  // R6
  wave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(inv_en) && !$past(preset_w)) |-> $stable(wave_out));

  // R10
  duty_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act != $past(duty_act)) |-> (($past(duty_w) && !$past(dbuf_en)) || irq_period));

endmodule

bind pulse_wave_timer pwt_checker #(.CNT_W(CNT_W)) u_pwt_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wave_out   (wave_out),
  .irq_duty   (irq_duty),
  .irq_period (irq_period),
  .cnt        (cnt_q),
  .duty_act   (duty_act),
  .run        (ctrl_q.run),
  .inv_en     (ctrl_q.inv_en),
  .dbuf_en    (ctrl_q.dbuf_en)
);

// File: tb/pulse_wave_timer_test.sv
module pulse_wave_timer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       tick_div1 = 1'b1;
  logic       tick_div4 = 1'b0;
  logic       tick_div16 = 1'b0;
  logic       ext_count = 1'b0;
  logic       wave_out, irq_duty, irq_period;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int pc = 0;

  always #4 clk = ~clk;

  pulse_wave_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tick_div1(tick_div1), .tick_div4(tick_div4), .tick_div16(tick_div16),
    .ext_count(ext_count), .wave_out(wave_out), .irq_duty(irq_duty),
    .irq_period(irq_period)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    pc = pc + 1;
    tick_div4  = (pc % 4 == 0);
    tick_div16 = (pc % 16 == 0);
    ext_count  = (pc % 3 == 0);
  end

  function automatic logic [7:0] ctl(input bit run, input bit dbuf,
                                     input logic [1:0] src, input bit inv);
    return {3'b000, inv, src, dbuf, run};
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_irq(input bit per, output int at);
    int n;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(per ? irq_period : irq_duty) && n < 4000);
    at = cyc;
    if (n >= 4000) begin
      checks++; failures++;
      $display("FAIL %s timeout actual=none expected=pulse", per ? "R3" : "R4");
    end
  endtask

  task automatic setup(input int p, input int d, input logic [1:0] src,
                       input bit inv, input bit dbuf);
    wr(2'd2, ctl(0, 0, src, inv));
    wr(2'd3, 8'd0);
    wr(2'd1, 8'(p));
    wr(2'd0, 8'(d));
    wr(2'd2, ctl(1, dbuf, src, inv));
  endtask

  task automatic measure(input int p, input int d, input int mul, input string req);
    int t0, t1, t2;
    wait_irq(1, t0);
    check("R5", "wave after period match", int'(wave_out), 0);
    wait_irq(0, t1);
    check(req, "duty match spacing", t1 - t0, mul * (d + 1));
    check("R5", "wave after duty match", int'(wave_out), 1);
    wait_irq(1, t2);
    check(req, "period match spacing", t2 - t0, mul * (p + 1));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int t0, t1, t2, cw, lvl, seen;
    int muls [4] = '{1, 4, 16, 3};
    int ps [3] = '{1, 3, 6};

    repeat (3) @(negedge clk);
    check("R1", "wave in reset", int'(wave_out), 0);
    check("R1", "irq in reset", int'(irq_duty | irq_period), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: stopped after reset, then default period of all ones
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq_duty || irq_period) seen++;
    end
    check("R1", "no matches while stopped", seen, 0);
    wr(2'd2, ctl(1, 0, 2'd0, 1));
    cw = cyc;
    wait_irq(0, t1);
    check("R1", "default duty 0 first match", t1 - cw, 1);
    wait_irq(1, t2);
    check("R1", "default period all ones", t2 - cw, 256);

    // R3 R4 R5: sweep of period and duty at full rate
    for (int p = 1; p <= 8; p++) begin
      for (int d = 0; d < p; d++) begin
        setup(p, d, 2'd0, 1, 0);
        measure(p, d, 1, "R3");
      end
    end
    setup(255, 254, 2'd0, 1, 0);
    measure(255, 254, 1, "R4");

    // R7: each count source scales the spacing
    for (int s = 1; s < 4; s++) begin
      foreach (ps[k]) begin
        setup(ps[k], 0, 2'(s), 1, 0);
        measure(ps[k], 0, muls[s], "R7");
        setup(ps[k], ps[k] - 1, 2'(s), 1, 0);
        measure(ps[k], ps[k] - 1, muls[s], "R7");
      end
    end

    // R8: stop, hold, restart
    setup(9, 2, 2'd0, 1, 0);
    wait_irq(1, t0);
    wr(2'd2, ctl(0, 0, 2'd0, 1));
    lvl = int'(wave_out);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (irq_duty || irq_period || int'(wave_out) != lvl) seen++;
    end
    check("R8", "no activity while stopped", seen, 0);
    wr(2'd2, ctl(1, 0, 2'd0, 1));
    cw = cyc;
    wait_irq(0, t1);
    check("R8", "restart duty spacing", t1 - cw, 3);

    // R9: direct duty write acts at once
    setup(9, 2, 2'd0, 1, 0);
    wait_irq(1, t0);
    wr(2'd0, 8'd6);
    wait_irq(0, t1);
    check("R9", "immediate duty", t1 - t0, 7);

    // R10: buffered duty write waits for the period match
    setup(9, 2, 2'd0, 1, 1);
    wait_irq(1, t0);
    wr(2'd0, 8'd6);
    wait_irq(0, t1);
    check("R10", "old duty kept", t1 - t0, 3);
    wait_irq(1, t2);
    wait_irq(0, t1);
    check("R10", "new duty after period", t1 - t2, 7);

    // R6: inversion disabled
    wr(2'd2, ctl(0, 0, 2'd0, 0));
    wr(2'd3, 8'd1);
    wr(2'd1, 8'd5);
    wr(2'd0, 8'd2);
    wr(2'd2, ctl(1, 0, 2'd0, 0));
    for (int i = 0; i < 2; i++) begin
      wait_irq(0, t1);
      check("R6", "wave held at duty match", int'(wave_out), 1);
      wait_irq(1, t2);
      check("R6", "wave held at period match", int'(wave_out), 1);
    end

    // R11: preset write, and priority over a match in the same cycle
    wr(2'd2, ctl(0, 0, 2'd0, 1));
    wr(2'd3, 8'd1);
    check("R11", "preset high", int'(wave_out), 1);
    wr(2'd3, 8'd0);
    check("R11", "preset low", int'(wave_out), 0);
    setup(4, 0, 2'd0, 1, 0);
    wait_irq(1, t0);
    wr(2'd3, 8'd0);
    check("R11", "match in preset cycle", int'(irq_duty), 1);
    check("R11", "preset beats toggle", int'(wave_out), 0);

    // R2: control byte read back through behaviour (source bits 3:2 = external)
    wr(2'd2, 8'b0000_1101);
    wait_irq(1, t0);
    wait_irq(1, t2);
    check("R2", "control field decode", t2 - t0, 15);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule